// File: doc/BRIEF.md
# Vector-Class Priority Interrupt Acceptor

This block sits in front of one processor core and decides which delivered interrupt, if any, the core should see. Each arriving vector message sets a bit in a pending register. Each vector the core has taken but not yet retired holds a bit in an in-service register. Both registers hold one bit per vector.

A vector's priority class is its upper four bits, so vectors compete in groups of sixteen. The block shows the highest pending vector on `irq_vector`. It raises `irq` only when the core's global enable flag is set and that vector's class is strictly above the class of the highest in-service vector.

When the core acknowledges, the vector moves from pending to in-service and the enable flag drops, as a gate entry would do. The handler must later write the end-of-interrupt register. Until it does, work of the same or a lower class is held back.

Top module: `vca_top`

## Requirements
- R1: After reset, nothing is pending or in service and the enable flag is clear, so `irq` is 0 and `irq_vector` is 0.
- R2: A message whose vector is below 32 is dropped and never raises `irq`.
- R3: `irq` is 0 whenever the enable flag is clear. `ien_set` sets the flag and `ien_clr` clears it. When both are strobed in the same cycle, the clear wins.
- R4: `irq` is 1 exactly when the flag is set, some vector is pending, and the highest pending vector's class (vector bits 7:4) is strictly greater than the highest in-service vector's class. With nothing in service, that in-service class is taken as 0.
- R5: `irq_vector` shows the highest-numbered pending vector, so within a class the larger vector wins. With nothing pending it shows 0.
- R6: A `core_ack` in a cycle where `irq` is 1 clears the presented vector's pending bit, sets its in-service bit and clears the enable flag, all at that edge. A `core_ack` while `irq` is 0 has no effect.
- R7: Any `eoi_wr` clears the highest set in-service bit. The value on `eoi_wdata` is ignored.
- R8: A message for a vector that is already pending merges with it, so one acknowledge consumes both.
- R9: A message that arrives in the same cycle as the acknowledge of the same vector leaves that vector pending again.
- R10: When `eoi_wr` and an effective `core_ack` fall in the same cycle, the EOI retires the in-service vector that was highest before that edge. The newly acknowledged vector stays in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A vector message is offered this cycle |
| msg_vector | input | 8 | Vector number carried by the message |
| core_ack | input | 1 | Core takes the presented interrupt |
| eoi_wr | input | 1 | Write strobe for the end-of-interrupt register |
| eoi_wdata | input | 32 | Write data for that register (ignored) |
| ien_set | input | 1 | Set the core's global enable flag |
| ien_clr | input | 1 | Clear the core's global enable flag |
| irq | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Vector currently presented |

## Verification
Two collisions can fall on one clock edge.

The first is an acknowledge together with an end-of-interrupt write. The bench provokes it by putting a low-class vector in service, raising a higher-class one, and strobing both in one cycle. It then checks that only the new vector still blocks lower classes.

The second is an acknowledge together with a new message for the vector being taken. The bench confirms that vector is presented again after its EOI.

A long pseudo-random stream also mixes messages, strobes, acknowledges and EOIs in every combination. It compares `irq` and `irq_vector` after each edge against a bench model kept from the requirements.

// File: rtl/vca_pkg.sv
package vca_pkg;
    localparam int unsigned VEC_W      = 8;
    localparam int unsigned NUM_VEC    = 1 << VEC_W;
    localparam int unsigned CLASS_W    = 4;
    localparam int unsigned RSVD_LIMIT = 32;
    localparam int unsigned EOI_DW     = 32;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [CLASS_W-1:0] cls_t;
    typedef logic [NUM_VEC-1:0] vmask_t;

    typedef struct packed {
        logic found;
        vec_t vec;
    } hit_t;

    function automatic cls_t class_of(input vec_t v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction
endpackage

// File: rtl/vca_bitvec.sv
module vca_bitvec #(
    parameter int unsigned N = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | set_mask;
    end

    // a bit set this cycle is present after the edge
    p_set_lands_r6: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/vca_find_top.sv
module vca_find_top #(
    parameter int unsigned N     = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic [N-1:0]     bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = i[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/vca_decode.sv
module vca_decode #(
    parameter int unsigned N     = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     mask
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign mask[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/vca_top.sv
module vca_top
    import vca_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [VEC_W-1:0]  msg_vector,
    input  logic              core_ack,
    input  logic              eoi_wr,
    input  logic [EOI_DW-1:0] eoi_wdata,
    input  logic              ien_set,
    input  logic              ien_clr,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam vec_t RSVD_VEC = vec_t'(RSVD_LIMIT);

    vmask_t pend_q, isr_q;
    vmask_t msg_mask, ack_mask, eoi_mask;
    hit_t   pend_hit, isr_hit;
    cls_t   pend_cls, isr_cls;
    logic   ien_q, msg_ok, ack_eff;
    logic   unused_wdata;

    assign unused_wdata = ^eoi_wdata;

    assign msg_ok  = msg_valid && (msg_vector >= RSVD_VEC);
    assign ack_eff = core_ack && irq;

    vca_find_top #(.N(NUM_VEC), .IDX_W(VEC_W)) u_pend_top (
        .bits(pend_q), .found(pend_hit.found), .idx(pend_hit.vec));
    vca_find_top #(.N(NUM_VEC), .IDX_W(VEC_W)) u_isr_top (
        .bits(isr_q), .found(isr_hit.found), .idx(isr_hit.vec));

    vca_decode #(.N(NUM_VEC), .IDX_W(VEC_W)) u_msg_dec (
        .en(msg_ok), .idx(msg_vector), .mask(msg_mask));
    vca_decode #(.N(NUM_VEC), .IDX_W(VEC_W)) u_ack_dec (
        .en(ack_eff), .idx(pend_hit.vec), .mask(ack_mask));
    vca_decode #(.N(NUM_VEC), .IDX_W(VEC_W)) u_eoi_dec (
        .en(eoi_wr && isr_hit.found), .idx(isr_hit.vec), .mask(eoi_mask));

    // pending: the ack clear applies first, so a same-cycle message re-arms
    vca_bitvec #(.N(NUM_VEC)) u_pend (
        .clk(clk), .rst(rst), .set_mask(msg_mask), .clr_mask(ack_mask), .q(pend_q));
    // in service: the EOI retires the entry that was highest before the edge
    vca_bitvec #(.N(NUM_VEC)) u_isr (
        .clk(clk), .rst(rst), .set_mask(ack_mask), .clr_mask(eoi_mask), .q(isr_q));

    always_ff @(posedge clk) begin
        if (rst)                     ien_q <= 1'b0;
        else if (ack_eff || ien_clr) ien_q <= 1'b0;
        else if (ien_set)            ien_q <= 1'b1;
    end

    assign pend_cls   = class_of(pend_hit.vec);
    assign isr_cls    = isr_hit.found ? class_of(isr_hit.vec) : '0;
    assign irq        = ien_q && pend_hit.found && (pend_cls > isr_cls);
    assign irq_vector = pend_hit.vec;

    // ---------------- assertions ----------------
    vec_t ack_vec_q;
    always_ff @(posedge clk) ack_vec_q <= irq_vector;

    p_rsvd_empty_r2: assert property (@(posedge clk) disable iff (rst)
        pend_q[RSVD_LIMIT-1:0] == '0);

    p_clr_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        ien_clr |=> !irq);

    p_ack_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (core_ack && irq) |=> (isr_q[ack_vec_q] && !irq));

    p_eoi_retires_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && (isr_q != '0) && !(core_ack && irq))
        |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: tb/vca_top_test.sv
`timescale 1ns/1ps
module vca_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        msg_valid, core_ack, eoi_wr, ien_set, ien_clr;
    logic [7:0]  msg_vector;
    logic [31:0] eoi_wdata;
    logic        irq;
    logic [7:0]  irq_vector;

    int checks = 0;
    int fails  = 0;
    bit mp[256];
    bit mi[256];
    bit men;
    logic [31:0] lfsr = 32'hACE1_1234;

    always #10 clk = ~clk;

    vca_top uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .core_ack(core_ack), .eoi_wr(eoi_wr), .eoi_wdata(eoi_wdata),
        .ien_set(ien_set), .ien_clr(ien_clr), .irq(irq), .irq_vector(irq_vector));

    function automatic int top_of(input bit a[256]);
        int r = -1;
        for (int i = 0; i < 256; i++) if (a[i]) r = i;
        return r;
    endfunction

    function automatic bit model_irq();
        int p = top_of(mp);
        int s = top_of(mi);
        int sc = (s >= 0) ? (s / 16) : 0;
        return men && (p >= 0) && ((p / 16) > sc);
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    task automatic check(input string tag);
        int p = top_of(mp);
        bit ei = model_irq();
        logic [7:0] ev = (p >= 0) ? 8'(p) : 8'd0;
        checks++;
        if (irq !== ei || irq_vector !== ev) begin
            fails++;
            $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                     tag, irq, irq_vector, ei, ev);
        end
    endtask

    task automatic step(input bit mv, input int vec, input bit ack, input bit eoi,
                        input bit st, input bit cl, input string tag);
        bit cur_irq;
        int p, s;
        msg_valid  = mv;
        msg_vector = 8'(vec);
        core_ack   = ack;
        eoi_wr     = eoi;
        eoi_wdata  = rnd();
        ien_set    = st;
        ien_clr    = cl;
        @(posedge clk);
        cur_irq = model_irq();
        p = top_of(mp);
        s = top_of(mi);
        if (eoi && s >= 0) mi[s] = 1'b0;
        if (ack && cur_irq) begin
            mp[p] = 1'b0;
            mi[p] = 1'b1;
        end
        if (mv && vec >= 32) mp[vec] = 1'b1;
        if ((ack && cur_irq) || cl) men = 1'b0;
        else if (st)                men = 1'b1;
        @(negedge clk);
        msg_valid = 0; core_ack = 0; eoi_wr = 0; ien_set = 0; ien_clr = 0;
        check(tag);
    endtask

    task automatic drain();
        for (int k = 0; k < 600; k++) begin
            if (top_of(mi) >= 0)      step(0, 0, 0, 1, 0, 0, "R7");
            else if (top_of(mp) >= 0) begin
                step(0, 0, 0, 0, 1, 0, "R4");
                step(0, 0, 1, 0, 0, 0, "R6");
            end
            else break;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; msg_valid = 0; msg_vector = 0; core_ack = 0; eoi_wr = 0;
        eoi_wdata = 0; ien_set = 0; ien_clr = 0; men = 0;
        for (int i = 0; i < 256; i++) begin mp[i] = 0; mi[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1");
        step(0, 0, 0, 0, 1, 0, "R1");
        step(0, 0, 0, 0, 0, 1, "R3");

        // R2: reserved vectors are dropped even while enabled
        step(0, 0, 0, 0, 1, 0, "R2");
        for (int v = 0; v < 32; v++) step(1, v, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, "R2");

        // single-vector sweep over every deliverable vector
        for (int v = 32; v < 256; v++) begin
            step(1, v, 0, 0, 0, 0, "R3");
            step(0, 0, 1, 0, 0, 0, "R6");   // ack while irq low: ignored
            step(0, 0, 0, 0, 1, 0, "R5");
            step(0, 0, 1, 0, 0, 0, "R6");
            step(0, 0, 0, 0, 1, 0, "R6");
            step(0, 0, 0, 1, 0, 0, "R7");
            step(0, 0, 0, 0, 0, 1, "R3");
        end

        // R3: simultaneous set and clear, clear wins
        step(1, 90, 0, 0, 1, 1, "R3");
        drain();

        // R4: every pair of in-service class and pending class
        for (int a = 2; a < 16; a++) begin
            for (int b = 2; b < 16; b++) begin
                step(1, a * 16 + 3, 0, 0, 1, 0, "R4");
                step(0, 0, 1, 0, 0, 0, "R6");
                step(1, b * 16 + 5, 0, 0, 1, 0, "R4");
                drain();
            end
        end

        // R5: higher vector wins inside one class
        step(1, 8'h45, 0, 0, 0, 0, "R5");
        step(1, 8'h4A, 0, 0, 1, 0, "R5");
        drain();

        // R8: duplicate messages merge
        step(1, 50, 0, 0, 0, 0, "R8");
        step(1, 50, 0, 0, 1, 0, "R8");
        step(0, 0, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 1, "R8");

        // R9: re-arrival in the acknowledge cycle
        step(1, 60, 0, 0, 1, 0, "R9");
        step(1, 60, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 1, 0, 0, "R9");
        drain();

        // R10: acknowledge and EOI in one cycle
        step(1, 40, 0, 0, 1, 0, "R10");
        step(0, 0, 1, 0, 0, 0, "R10");
        step(1, 200, 0, 0, 1, 0, "R10");
        step(0, 0, 1, 1, 0, 0, "R10");
        step(1, 100, 0, 0, 1, 0, "R10");
        step(0, 0, 0, 1, 0, 0, "R10");
        drain();

        // pseudo-random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r = rnd();
            step(r[0], int'(r[15:8]), r[1] & r[2], r[3] & r[4] & r[5],
                 r[6], r[7] & r[16] & r[17], "R4");
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule